// File: doc/BRIEF.md
# Sixteen-Bit Timer/Counter with Selectable Top

This block is a 16-bit timer/counter that sits on an 8-bit register bus. Software programs a counter, a compare word and a capture word, picks a waveform mode and a clock divider, and the block counts up, wraps at a top value chosen by the mode, and raises an overflow flag and a compare flag. Each flag can drive its own interrupt request when its enable bit and a global interrupt enable are both set.

The counter's top can be the full 16-bit range, a fixed 8-, 9- or 10-bit limit, the capture word, or the compare word. Some modes raise the overflow flag when they wrap at the top and some do not. The interrupt controller is outside the block. It sees two request lines and returns one acknowledge pulse per line, and each pulse clears the flag it serviced.

Top module: `timer16`

## Requirements
- R1: After reset every register reads 0x00, the counter is stopped and both interrupt requests are low.
- R2: With clock select 1, the counter advances by exactly one on every clock. For example, 0x2233 becomes 0x2234 one clock after it is loaded.
- R3: Each 16-bit word is split into two byte addresses, with the low byte at the even address and the high byte at the next address. The addresses are counter 4/5, compare 6/7 and capture 8/9. Writing a high byte only loads a shared holding byte. Writing the low byte then commits the holding byte and the written byte together, so writing a high byte alone never changes the counter.
- R4: Control A (address 0) holds the mode bits 1:0 in its bits 1:0. Control B (address 1) holds the mode bits 3:2 in its bits 4:3 and the clock select in its bits 2:0. Unused bits read as 0.
- R5: The compare flag is bit 1 of the flag register (address 3). It is set on the clock whose increment makes the counter equal to the compare word.
- R6: In mode 0, the counter wraps from 0xFFFF to 0 and sets the overflow flag, which is bit 0 of the flag register.
- R7: Modes 5, 6 and 7 wrap at 0x00FF, 0x01FF and 0x03FF respectively, and each wrap sets the overflow flag.
- R8: Modes 12 and 14 clear the counter on the increment after it equals the capture word. Mode 12 leaves the overflow flag untouched when it does this, and mode 14 sets it.
- R9: Modes 4 and 15 clear the counter on the increment after it equals the compare word. Mode 4 does not set the overflow flag at that point, and mode 15 does.
- R10: Clock select 0 holds the counter. Values 6 and 7 also hold it. Values 2, 3, 4 and 5 advance the counter once every 8, 64, 256 and 1024 clocks, taken from a free-running prescaler.
- R11: Writing 1 to a flag bit clears that flag, and writing 0 to it has no effect. When hardware sets a flag in the same clock as a software clear, the flag ends up set.
- R12: The overflow request is high when the overflow flag, mask bit 0 (address 2) and the global enable are all high. The compare request uses mask bit 1 in the same way. An acknowledge pulse clears its own flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| gie | input | 1 | Global interrupt enable |
| ackOvf | input | 1 | Overflow request acknowledge |
| ackCmp | input | 1 | Compare request acknowledge |
| irqOvf | output | 1 | Overflow interrupt request |
| irqCmp | output | 1 | Compare interrupt request |

## Verification
The checker assumes that register writes arrive as single-cycle strobes with a stable address. It also assumes that the counter word is not rewritten in the clock the checker uses to judge an increment or a wrap. The stepping and wrap properties are therefore gated on there being no counter load. The bench keeps within these assumptions by always stopping the clock select before it loads the counter, compare or capture words. It also clears the flags before each run and restarts counting with a single write to control B, so every counted clock lies after the configuration has settled.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 10;
  localparam int ADDR_W = 4;
  localparam int MODE_W = 4;
  localparam int CS_W   = 3;
  localparam int FLAG_N = 2;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_CMP = 1;

  localparam logic [ADDR_W-1:0] ADR_CTRLA = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRLB = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_FLAG  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CNTL  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_CNTH  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_CMPL  = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_CMPH  = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_CAPL  = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CAPH  = 4'd9;

  typedef enum logic [2:0] {
    TOP_FULL, TOP_FIX8, TOP_FIX9, TOP_FIX10, TOP_CAP, TOP_CMPA
  } topSel_e;

  typedef struct packed {
    topSel_e topSel;
    logic    ovfAtTop;
  } modeCfg_t;

  typedef struct packed {
    logic              cntLoad;
    logic              cmpLoad;
    logic              capLoad;
    logic [CNT_W-1:0]  word;
    logic [MODE_W-1:0] mode;
    logic [CS_W-1:0]   cs;
  } dpCtl_t;

  function automatic modeCfg_t decodeMode(input logic [MODE_W-1:0] m);
    modeCfg_t c;
    case (m)
      4'd4:    c = '{topSel: TOP_CMPA,  ovfAtTop: 1'b0};
      4'd5:    c = '{topSel: TOP_FIX8,  ovfAtTop: 1'b1};
      4'd6:    c = '{topSel: TOP_FIX9,  ovfAtTop: 1'b1};
      4'd7:    c = '{topSel: TOP_FIX10, ovfAtTop: 1'b1};
      4'd12:   c = '{topSel: TOP_CAP,   ovfAtTop: 1'b0};
      4'd14:   c = '{topSel: TOP_CAP,   ovfAtTop: 1'b1};
      4'd15:   c = '{topSel: TOP_CMPA,  ovfAtTop: 1'b1};
      default: c = '{topSel: TOP_FULL,  ovfAtTop: 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/timer16_ctrl.sv
module timer16_ctrl
  import timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              ovfEvt,
  input  logic              cmpEvt,
  input  logic              ackOvf,
  input  logic              ackCmp,
  output dpCtl_t            dpCtl,
  output logic [1:0]        ctrlA,
  output logic [4:0]        ctrlB,
  output logic [FLAG_N-1:0] mask,
  output logic [FLAG_N-1:0] flags
);

  logic [BYTE_W-1:0] tempHi;
  logic              hiWr;
  logic [FLAG_N-1:0] swClr;
  logic [FLAG_N-1:0] hwSet;
  logic [FLAG_N-1:0] ackVec;

  assign hiWr = wrEn && (addr == ADR_CNTH || addr == ADR_CMPH || addr == ADR_CAPH);

  // holding byte for the upper half of a word write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     tempHi <= '0;
    else if (hiWr) tempHi <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlA <= '0;
      ctrlB <= '0;
      mask  <= '0;
    end else if (wrEn) begin
      case (addr)
        ADR_CTRLA: ctrlA <= wrData[1:0];
        ADR_CTRLB: ctrlB <= wrData[4:0];
        ADR_MASK:  mask  <= wrData[FLAG_N-1:0];
        default: ;
      endcase
    end
  end

  // strobes towards the datapath; low-byte write commits the whole word
  always_comb begin
    dpCtl         = '0;
    dpCtl.cntLoad = wrEn && (addr == ADR_CNTL);
    dpCtl.cmpLoad = wrEn && (addr == ADR_CMPL);
    dpCtl.capLoad = wrEn && (addr == ADR_CAPL);
    dpCtl.word    = {tempHi, wrData};
    dpCtl.mode    = {ctrlB[4:3], ctrlA};
    dpCtl.cs      = ctrlB[CS_W-1:0];
  end

  assign swClr  = (wrEn && addr == ADR_FLAG) ? wrData[FLAG_N-1:0] : '0;
  assign hwSet  = {cmpEvt, ovfEvt};
  assign ackVec = {ackCmp, ackOvf};

  // hardware set outranks software clear and acknowledge
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= hwSet[i] | (flags[i] & ~swClr[i] & ~ackVec[i]);
    end
  end

endmodule

// File: rtl/timer16_dp.sv
module timer16_dp
  import timer16_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cap,
  output logic             ovfEvt,
  output logic             cmpEvt
);

  localparam logic [CNT_W-1:0] TOP_8BIT  = CNT_W'((32'd1 << 8)  - 32'd1);
  localparam logic [CNT_W-1:0] TOP_9BIT  = CNT_W'((32'd1 << 9)  - 32'd1);
  localparam logic [CNT_W-1:0] TOP_10BIT = CNT_W'((32'd1 << 10) - 32'd1);

  logic [PRE_W-1:0] pre;
  logic             tick;
  modeCfg_t         cfg;
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] nxt;
  logic             wrapOvf;
  logic             step;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pre <= '0;
    else       pre <= pre + 1'b1;
  end

  always_comb begin
    case (dpCtl.cs)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre[2:0];
      3'd3:    tick = &pre[5:0];
      3'd4:    tick = &pre[7:0];
      3'd5:    tick = &pre[9:0];
      default: tick = 1'b0;
    endcase
  end

  assign cfg = decodeMode(dpCtl.mode);

  always_comb begin
    case (cfg.topSel)
      TOP_FIX8:  top = TOP_8BIT;
      TOP_FIX9:  top = TOP_9BIT;
      TOP_FIX10: top = TOP_10BIT;
      TOP_CAP:   top = cap;
      TOP_CMPA:  top = cmp;
      default:   top = '1;
    endcase
  end

  always_comb begin
    if (cnt == top) begin
      nxt     = '0;
      wrapOvf = cfg.ovfAtTop;
    end else if (cnt == '1) begin
      nxt     = '0;
      wrapOvf = 1'b1;
    end else begin
      nxt     = cnt + 1'b1;
      wrapOvf = 1'b0;
    end
  end

  assign step   = tick && !dpCtl.cntLoad;
  assign ovfEvt = step && wrapOvf;
  assign cmpEvt = step && (nxt == cmp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (dpCtl.cntLoad) cnt <= dpCtl.word;
    else if (tick)          cnt <= nxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmp <= '0;
      cap <= '0;
    end else begin
      if (dpCtl.cmpLoad) cmp <= dpCtl.word;
      if (dpCtl.capLoad) cap <= dpCtl.word;
    end
  end

endmodule

// File: rtl/timer16.sv
module timer16
  import timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              gie,
  input  logic              ackOvf,
  input  logic              ackCmp,
  output logic              irqOvf,
  output logic              irqCmp
);

  dpCtl_t            dpCtl;
  logic [1:0]        ctrlA;
  logic [4:0]        ctrlB;
  logic [FLAG_N-1:0] mask;
  logic [FLAG_N-1:0] flags;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic [CNT_W-1:0]  cap;
  logic              ovfEvt;
  logic              cmpEvt;
  logic [MODE_W-1:0] modeVal;
  logic [CS_W-1:0]   csVal;
  logic              cntLoad;

  timer16_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .ovfEvt(ovfEvt), .cmpEvt(cmpEvt), .ackOvf(ackOvf), .ackCmp(ackCmp),
    .dpCtl(dpCtl), .ctrlA(ctrlA), .ctrlB(ctrlB), .mask(mask), .flags(flags)
  );

  timer16_dp u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .cnt(cnt), .cmp(cmp), .cap(cap),
    .ovfEvt(ovfEvt), .cmpEvt(cmpEvt)
  );

  assign modeVal = dpCtl.mode;
  assign csVal   = dpCtl.cs;
  assign cntLoad = dpCtl.cntLoad;

  always_comb begin
    case (addr)
      ADR_CTRLA: rdData = {6'b0, ctrlA};
      ADR_CTRLB: rdData = {3'b0, ctrlB};
      ADR_MASK:  rdData = {{(BYTE_W-FLAG_N){1'b0}}, mask};
      ADR_FLAG:  rdData = {{(BYTE_W-FLAG_N){1'b0}}, flags};
      ADR_CNTL:  rdData = cnt[BYTE_W-1:0];
      ADR_CNTH:  rdData = cnt[CNT_W-1:BYTE_W];
      ADR_CMPL:  rdData = cmp[BYTE_W-1:0];
      ADR_CMPH:  rdData = cmp[CNT_W-1:BYTE_W];
      ADR_CAPL:  rdData = cap[BYTE_W-1:0];
      ADR_CAPH:  rdData = cap[CNT_W-1:BYTE_W];
      default:   rdData = '0;
    endcase
  end

  assign irqOvf = gie & flags[FLAG_OVF] & mask[FLAG_OVF];
  assign irqCmp = gie & flags[FLAG_CMP] & mask[FLAG_CMP];

endmodule

// File: rtl/timer16_chk.sv
module timer16_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  mode,
  input logic [2:0]  cs,
  input logic        cntLoad,
  input logic [15:0] cnt,
  input logic [15:0] cap,
  input logic [1:0]  flags,
  input logic        ovfEvt,
  input logic        wrEn,
  input logic [3:0]  addr,
  input logic [7:0]  wrData,
  input logic        gie,
  input logic        irqOvf,
  input logic        irqCmp
);

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'd0 && cs == 3'd1 && !cntLoad && cnt != 16'hFFFF) |=> cnt == $past(cnt) + 16'd1);

  p_wrap_ovf_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'd0 && cs == 3'd1 && !cntLoad && cnt == 16'hFFFF) |=> (cnt == 16'd0 && flags[0]));

  p_cap_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 4'd12 || mode == 4'd14) && cs == 3'd1 && !cntLoad && cnt == cap) |=> cnt == 16'd0);

  p_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cs == 3'd0 && !cntLoad) |=> $stable(cnt));

  p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'd5 && cs == 3'd0) |=> $stable(cnt));

  p_swclr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'd3 && wrData[0] && !ovfEvt) |=> !flags[0]);

  p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    (irqOvf || irqCmp) |-> gie);

endmodule

bind timer16 timer16_chk u_chk (
  .clk(clk), .rstN(rstN), .mode(modeVal), .cs(csVal), .cntLoad(cntLoad),
  .cnt(cnt), .cap(cap), .flags(flags), .ovfEvt(ovfEvt), .wrEn(wrEn),
  .addr(addr), .wrData(wrData), .gie(gie), .irqOvf(irqOvf), .irqCmp(irqCmp)
);

// File: tb/tb_timer16.sv
`timescale 1ns/1ps
module tb_timer16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       gie = 1'b0;
  logic       ackOvf = 1'b0;
  logic       ackCmp = 1'b0;
  logic       irqOvf;
  logic       irqCmp;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  timer16 dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .gie(gie), .ackOvf(ackOvf), .ackCmp(ackCmp),
    .irqOvf(irqOvf), .irqCmp(irqCmp)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0]  req;
    logic [7:0]  ctlA;
    logic [7:0]  ctlB;
    logic [15:0] cntIn;
    logic [15:0] cmpIn;
    logic [15:0] capIn;
    logic [15:0] nClk;
    logic [15:0] expCnt;
    logic [7:0]  expFlg;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{8'd2,  8'h00, 8'h01, 16'h2233, 16'h1234, 16'h0000, 16'd1,   16'h2234, 8'h00}, // R2 step
    '{8'd5,  8'h00, 8'h01, 16'h10EE, 16'h10EF, 16'h0000, 16'd1,   16'h10EF, 8'h02}, // R5 compare
    '{8'd7,  8'h03, 8'h09, 16'h03FF, 16'h1234, 16'h0000, 16'd1,   16'h0000, 8'h01}, // R7 mode 7
    '{8'd8,  8'h00, 8'h19, 16'h500F, 16'h1234, 16'h5010, 16'd2,   16'h0000, 8'h00}, // R8 mode 12
    '{8'd6,  8'h00, 8'h01, 16'hFFFE, 16'h1234, 16'h0000, 16'd2,   16'h0000, 8'h01}, // R6 mode 0
    '{8'd7,  8'h01, 8'h09, 16'h00FE, 16'h1234, 16'h0000, 16'd3,   16'h0001, 8'h01}, // R7 mode 5
    '{8'd7,  8'h02, 8'h09, 16'h01FF, 16'h1234, 16'h0000, 16'd1,   16'h0000, 8'h01}, // R7 mode 6
    '{8'd8,  8'h02, 8'h19, 16'h003F, 16'h1234, 16'h0040, 16'd2,   16'h0000, 8'h01}, // R8 mode 14
    '{8'd9,  8'h00, 8'h09, 16'h00FF, 16'h0100, 16'h0000, 16'd2,   16'h0000, 8'h02}, // R9 mode 4
    '{8'd9,  8'h03, 8'h19, 16'h001F, 16'h0020, 16'h0000, 16'd2,   16'h0000, 8'h03}, // R9 mode 15
    '{8'd10, 8'h00, 8'h00, 16'h4444, 16'h1234, 16'h0000, 16'd5,   16'h4444, 8'h00}, // R10 stop
    '{8'd10, 8'h00, 8'h02, 16'h0000, 16'h1234, 16'h0000, 16'd64,  16'h0008, 8'h00}, // R10 div 8
    '{8'd10, 8'h00, 8'h03, 16'h0000, 16'h1234, 16'h0000, 16'd128, 16'h0002, 8'h00}, // R10 div 64
    '{8'd10, 8'h00, 8'h04, 16'h0000, 16'h1234, 16'h0000, 16'd256, 16'h0001, 8'h00}, // R10 div 256
    '{8'd10, 8'h00, 8'h06, 16'h0077, 16'h1234, 16'h0000, 16'd10,  16'h0077, 8'h00}  // R10 sel 6
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] d);
    wr(lo + 4'd1, d[15:8]);
    wr(lo, d[7:0]);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] d);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 4'd1, h);
    d = {h, l};
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), b);
      chk($sformatf("R1 reg %0d after reset", a), b, 0);
    end
    chk("R1 irq after reset", {irqOvf, irqCmp}, 0);

    // table-driven runs
    for (int v = 0; v < NVEC; v++) begin
      wr(4'd1, 8'h00);
      wr(4'd0, VECS[v].ctlA);
      wr(4'd3, 8'hFF);
      wr16(4'd4, VECS[v].cntIn);
      wr16(4'd6, VECS[v].cmpIn);
      wr16(4'd8, VECS[v].capIn);
      wr(4'd1, VECS[v].ctlB);
      repeat (int'(VECS[v].nClk)) @(posedge clk);
      #1;
      rd16(4'd4, w);
      chk($sformatf("R%0d vector %0d counter", VECS[v].req, v), w, VECS[v].expCnt);
      rd(4'd3, b);
      chk($sformatf("R%0d vector %0d flags", VECS[v].req, v), b, VECS[v].expFlg);
    end
    wr(4'd1, 8'h00);

    // R3 high byte alone is held back
    wr16(4'd4, 16'h1111);
    wr(4'd5, 8'hAB);
    rd16(4'd4, w);
    chk("R3 counter after high write only", w, 16'h1111);
    wr(4'd4, 8'hCD);
    rd16(4'd4, w);
    chk("R3 counter after low commit", w, 16'hABCD);
    wr16(4'd8, 16'h5AA5);
    rd16(4'd8, w);
    chk("R3 capture word", w, 16'h5AA5);

    // R4 control field widths
    wr(4'd0, 8'hFF);
    rd(4'd0, b);
    chk("R4 control A readback", b, 8'h03);
    wr(4'd1, 8'hFF);
    rd(4'd1, b);
    chk("R4 control B readback", b, 8'h1F);
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h00);

    // R11 hardware set beats software clear
    wr(4'd3, 8'hFF);
    wr16(4'd4, 16'hFFFE);
    wr(4'd1, 8'h01);
    @(posedge clk);
    wr(4'd3, 8'h01);
    rd(4'd3, b);
    chk("R11 set wins over clear", b, 8'h01);
    wr(4'd1, 8'h00);
    wr(4'd3, 8'h02);
    rd(4'd3, b);
    chk("R11 writing 0 leaves overflow flag", b, 8'h01);
    wr(4'd3, 8'h01);
    rd(4'd3, b);
    chk("R11 writing 1 clears flag", b, 8'h00);

    // R12 requests and acknowledge
    wr16(4'd4, 16'hFFFF);
    wr(4'd1, 8'h01);
    wr(4'd1, 8'h00);
    wr(4'd2, 8'h01);
    gie = 1'b1;
    #1 chk("R12 overflow request raised", irqOvf, 1);
    gie = 1'b0;
    #1 chk("R12 request gated by global enable", irqOvf, 0);
    gie = 1'b1;
    @(negedge clk) ackOvf = 1'b1;
    @(posedge clk);
    #1 ackOvf = 1'b0;
    chk("R12 overflow request after ack", irqOvf, 0);
    rd(4'd3, b);
    chk("R12 overflow flag after ack", b, 8'h00);
    wr16(4'd6, 16'h0005);
    wr16(4'd4, 16'h0004);
    wr(4'd1, 8'h01);
    wr(4'd1, 8'h00);
    wr(4'd2, 8'h02);
    #1 chk("R12 compare request raised", irqCmp, 1);
    @(negedge clk) ackCmp = 1'b1;
    @(posedge clk);
    #1 ackCmp = 1'b0;
    chk("R12 compare request after ack", irqCmp, 0);

    finishRun();
  end

endmodule